// File: doc/BRIEF.md
# Single-wire battery-gauge bus master

This block is a register-mapped master for a single-wire, open-drain bus of the kind used by battery fuel-gauge chips. Software writes a byte-wide register port to load a transmit byte, pick an operation in the control register and launch it. Three operations exist: shifting a byte out to the slave, shifting a byte in from it, and sending a long low break pulse that resets the slave's interface. Completion shows up three ways. The launch bit clears itself, a sticky flag is set in the event register, and an interrupt line is raised if it is enabled.

On the wire every bit starts with a low pulse, and the least significant bit goes first. A short low pulse means one and a long one means zero. When receiving, the master releases the line and waits for the slave to pull it low. It then samples the synchronised line a fixed number of cycles after that falling edge. If the slave never answers within a window, the operation ends with the timeout flag instead. A soft reset returns every register to its reset value, and a status bit reports when the block is ready again.

Top module: `sgw_master`

## Requirements
- R1: After reset, the status register (offset 0x18) reads 0 for RST_CYC cycles and then reads 0x01. Control (0x0C), event (0x10), transmit (0x04) and receive (0x08) read 0x00, `irq` is 0 and the line is released.
- R2: Offset 0x00 reads the major version in bits 7:4 and the minor version in bits 3:0.
- R3: Writing control with bit 4 (start) set, bit 2 (break) clear and bit 1 (direction) clear sends the transmit byte LSB first. Each bit cell is CELL cycles long and begins with a drive-low pulse of BIT1_LOW cycles for a one or BIT0_LOW cycles for a zero.
- R4: When a send ends, event bit 2 sets and control bit 4 reads 0.
- R5: Writing control with bits 4 and 2 set drives the line low for BREAK_LOW cycles and then releases it for BREAK_REC cycles. Event bit 0 then sets, and control bits 4 and 2 both read 0.
- R6: Writing control with bit 4 and bit 1 set never drives the line. Each slave falling edge starts a bit, and the line is sampled RX_SAMPLE cycles after the synchronised edge: high gives 1 and low gives 0, LSB first. After 8 bits the byte appears at 0x08, event bit 1 sets and control bit 4 clears.
- R7: During a receive, if no falling edge arrives within RX_WAIT cycles, event bit 0 sets and bit 1 does not. Control bit 4 clears and 0x08 keeps its earlier value, including when the slave stops part-way through a byte.
- R8: A read of 0x10 returns the event flags and clears them. A second read returns 0x00.
- R9: `irq` is high exactly when an event flag is set and control bit 6 (interrupt enable) is 1.
- R10: While an operation runs, a control write changes only bits 6, 5 and 0; bits 4, 2 and 1 hold. A transmit-register write does not change the byte being sent.
- R11: Writing 0x14 with bit 1 set makes the status register read 0 at once. The status register returns to 0x01 after RST_CYC cycles, with all other registers at their reset values; bit 1 of 0x14 always reads 0.
- R12: Control bits 6, 5 and 0 and bit 0 of 0x14 (auto-idle) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; a read of 0x10 clears the flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| line_drive_low | output | 1 | 1 pulls the bus low; 0 releases it |
| line_in | input | 1 | Sampled bus level |

## Verification
The assertions assume that `rst_n` is held across at least one clock edge. They also assume that each register strobe lasts a single cycle with a stable address, and that the slave pulls the bus low only while the master has released it. The bench drives one strobe at a time for exactly one edge. It pulls the line low only during a receive, and it keeps the gap between slave edges well inside the receive window except in the deliberate timeout cases. Every transmit and receive byte value is swept, and the bench decodes the pulses on the line arithmetically from the configured widths.

// File: rtl/sgw_pkg.sv
// Shared register offsets, bit positions and types of the single-wire master.
package sgw_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_REV   = 5'h00;
    localparam logic [ADDR_W-1:0] A_TXD   = 5'h04;
    localparam logic [ADDR_W-1:0] A_RXD   = 5'h08;
    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_EVT   = 5'h10;
    localparam logic [ADDR_W-1:0] A_SCFG  = 5'h14;
    localparam logic [ADDR_W-1:0] A_SSTAT = 5'h18;

    // control bit positions
    localparam int C_IE   = 6;
    localparam int C_CE   = 5;
    localparam int C_GO   = 4;
    localparam int C_INIT = 2;
    localparam int C_DIR  = 1;
    localparam int C_MODE = 0;

    // event flag positions
    localparam int F_TX = 2;
    localparam int F_RX = 1;
    localparam int F_TO = 0;

    // system config positions
    localparam int S_SRST  = 1;
    localparam int S_AIDLE = 0;

    typedef enum logic [1:0] {OP_SEND, OP_RECV, OP_BREAK} op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_BRK_LO, ST_BRK_REC, ST_TX_CELL, ST_RX_WAIT, ST_RX_SAMP
    } eng_st_e;
endpackage

// File: rtl/sgw_sync.sv
// Multi-flop synchroniser for the sampled bus level.
// Assumes STAGES >= 2; resets to the idle (released) level.
module sgw_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= {STAGES{IDLE_VAL}};
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/sgw_rstseq.sv
// Reset sequencer: after a hard or soft reset it holds the core in reset
// for RST_CYC cycles, then raises rst_done.
// Assumes soft_req is a single-cycle pulse.
module sgw_rstseq #(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_req,
    output logic rst_done
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt;

    // count out the reset hold, restarting on a soft request
    always_ff @(posedge clk) begin
        if (!rst_n || soft_req) begin
            cnt      <= '0;
            rst_done <= 1'b0;
        end else if (!rst_done) begin
            if (cnt == CW'(RST_CYC - 1)) rst_done <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sgw_engine.sv
// Bit engine: runs one send, receive or break operation on the wire.
// Assumes start is seen only while idle, and that every low pulse and window
// is shorter than the counter range derived below.
module sgw_engine
    import sgw_pkg::*;
#(
    parameter int BIT_W     = 8,
    parameter int CELL      = 24,
    parameter int BIT1_LOW  = 5,
    parameter int BIT0_LOW  = 15,
    parameter int BREAK_LOW = 40,
    parameter int BREAK_REC = 12,
    parameter int RX_WAIT   = 64,
    parameter int RX_SAMPLE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  op_e              op,
    input  logic [BIT_W-1:0] tx_byte,
    input  logic             line_s,
    output logic             drive_low,
    output logic             busy,
    output logic             done_tx,
    output logic             done_rx,
    output logic             done_to,
    output logic [BIT_W-1:0] rx_byte
);
    localparam int M1    = (CELL > BREAK_LOW) ? CELL : BREAK_LOW;
    localparam int M2    = (M1 > BREAK_REC) ? M1 : BREAK_REC;
    localparam int M3    = (M2 > RX_WAIT) ? M2 : RX_WAIT;
    localparam int MAXC  = (M3 > RX_SAMPLE) ? M3 : RX_SAMPLE;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int BI_W  = (BIT_W > 1) ? $clog2(BIT_W) : 1;

    eng_st_e          state;
    logic [CNT_W-1:0] cnt;
    logic [BI_W-1:0]  bidx;
    logic [BIT_W-1:0] shreg;
    logic             line_q;
    logic             fall;
    logic             last_bit;
    logic [CNT_W-1:0] low_len;

    assign fall     = line_q & ~line_s;
    assign last_bit = (bidx == BI_W'(BIT_W - 1));
    assign low_len  = shreg[0] ? CNT_W'(BIT1_LOW) : CNT_W'(BIT0_LOW);

    // wire drive and completion pulses decoded from the phase counter
    always_comb begin
        busy      = (state != ST_IDLE);
        drive_low = (state == ST_BRK_LO) ||
                    ((state == ST_TX_CELL) && (cnt < low_len));
        done_tx   = (state == ST_TX_CELL) && (cnt == CNT_W'(CELL - 1)) && last_bit;
        done_rx   = (state == ST_RX_SAMP) && (cnt == CNT_W'(RX_SAMPLE - 1)) && last_bit;
        done_to   = ((state == ST_BRK_REC) && (cnt == CNT_W'(BREAK_REC - 1))) ||
                    ((state == ST_RX_WAIT) && !fall && (cnt == CNT_W'(RX_WAIT - 1)));
        rx_byte   = {line_s, shreg[BIT_W-1:1]};
    end

    // operation sequencer: phase state, cycle counter, bit index and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            line_q <= 1'b1;
        end else begin
            line_q <= line_s;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt  <= '0;
                        bidx <= '0;
                        case (op)
                            OP_SEND: begin
                                shreg <= tx_byte;
                                state <= ST_TX_CELL;
                            end
                            OP_RECV: begin
                                shreg <= '0;
                                state <= ST_RX_WAIT;
                            end
                            default: state <= ST_BRK_LO;
                        endcase
                    end
                end
                ST_BRK_LO: begin
                    if (cnt == CNT_W'(BREAK_LOW - 1)) begin
                        cnt   <= '0;
                        state <= ST_BRK_REC;
                    end else cnt <= cnt + 1'b1;
                end
                ST_BRK_REC: begin
                    if (cnt == CNT_W'(BREAK_REC - 1)) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                ST_TX_CELL: begin
                    if (cnt == CNT_W'(CELL - 1)) begin
                        cnt <= '0;
                        if (last_bit) state <= ST_IDLE;
                        else begin
                            bidx  <= bidx + 1'b1;
                            shreg <= {1'b0, shreg[BIT_W-1:1]};
                        end
                    end else cnt <= cnt + 1'b1;
                end
                ST_RX_WAIT: begin
                    if (fall) begin
                        cnt   <= '0;
                        state <= ST_RX_SAMP;
                    end else if (cnt == CNT_W'(RX_WAIT - 1)) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                ST_RX_SAMP: begin
                    if (cnt == CNT_W'(RX_SAMPLE - 1)) begin
                        shreg <= {line_s, shreg[BIT_W-1:1]};
                        cnt   <= '0;
                        if (last_bit) state <= ST_IDLE;
                        else begin
                            bidx  <= bidx + 1'b1;
                            state <= ST_RX_WAIT;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgw_regs.sv
// Register file: decodes the byte-wide port, holds control, data and event
// flags, launches operations and retires them on the engine's done pulses.
// Assumes reg_wr and reg_rd are single-cycle strobes.
module sgw_regs
    import sgw_pkg::*;
#(
    parameter int REV_MAJOR = 1,
    parameter int REV_MINOR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rst_done,
    output logic              soft_req,
    output logic              start,
    output op_e               op,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              done_tx,
    input  logic              done_rx,
    input  logic              done_to,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              irq,
    output logic              ie,
    output logic              go,
    output logic              init,
    output logic              dir
);
    logic              ce, mode, aidle;
    logic [DATA_W-1:0] rxd;
    logic [2:0]        flags;
    logic [2:0]        flags_nx;
    logic              wr_ctrl;
    logic              any_done;

    assign wr_ctrl  = wr && (addr == A_CTRL);
    assign any_done = done_tx | done_rx | done_to;
    assign start    = wr_ctrl && wdata[C_GO] && !go;
    assign soft_req = wr && (addr == A_SCFG) && wdata[S_SRST];
    assign irq      = ie && (flags != 3'b000);

    // pick the operation from the break and direction bits of the write
    always_comb begin
        if (wdata[C_INIT])     op = OP_BREAK;
        else if (wdata[C_DIR]) op = OP_RECV;
        else                   op = OP_SEND;
    end

    // control bits: settings always writable, launch bits locked while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= 1'b0; ce <= 1'b0; mode <= 1'b0;
            go <= 1'b0; init <= 1'b0; dir <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ie   <= wdata[C_IE];
                ce   <= wdata[C_CE];
                mode <= wdata[C_MODE];
                if (!go) begin
                    go   <= wdata[C_GO];
                    init <= wdata[C_INIT];
                    dir  <= wdata[C_DIR];
                end
            end
            if (any_done) begin
                go   <= 1'b0;
                init <= 1'b0;
            end
        end
    end

    // data registers and the auto-idle setting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            rxd     <= '0;
            aidle   <= 1'b0;
        end else begin
            if (wr && (addr == A_TXD))  tx_byte <= wdata;
            if (wr && (addr == A_SCFG)) aidle   <= wdata[S_AIDLE];
            if (done_rx)                rxd     <= rx_byte;
        end
    end

    // event flags: cleared by a read, a new event in the same cycle wins
    always_comb begin
        flags_nx = flags;
        if (rd && (addr == A_EVT)) flags_nx = 3'b000;
        if (done_tx) flags_nx[F_TX] = 1'b1;
        if (done_rx) flags_nx[F_RX] = 1'b1;
        if (done_to) flags_nx[F_TO] = 1'b1;
    end

    // hold the event flags
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= 3'b000;
        else        flags <= flags_nx;
    end

    // read multiplexer
    always_comb begin
        case (addr)
            A_REV:   rdata = {4'(REV_MAJOR), 4'(REV_MINOR)};
            A_TXD:   rdata = tx_byte;
            A_RXD:   rdata = rxd;
            A_CTRL:  rdata = {1'b0, ie, ce, go, 1'b0, init, dir, mode};
            A_EVT:   rdata = {5'b0, flags};
            A_SCFG:  rdata = {6'b0, 1'b0, aidle};
            A_SSTAT: rdata = {7'b0, rst_done};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/sgw_master.sv
// Single-wire bus master top: register file, bit engine, line synchroniser
// and reset sequencer. The core is held in reset until rst_done is high.
// Assumes line_in is pulled high externally when nobody drives it.
module sgw_master
    import sgw_pkg::*;
#(
    parameter int REV_MAJOR = 1,
    parameter int REV_MINOR = 0,
    parameter int CELL      = 24,
    parameter int BIT1_LOW  = 5,
    parameter int BIT0_LOW  = 15,
    parameter int BREAK_LOW = 40,
    parameter int BREAK_REC = 12,
    parameter int RX_WAIT   = 64,
    parameter int RX_SAMPLE = 10,
    parameter int RST_CYC   = 8,
    parameter int SYNC_FF   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       line_drive_low,
    input  logic       line_in
);
    logic              rst_done, soft_req, core_rst_n;
    logic              line_s;
    logic              eng_start, eng_busy;
    logic              d_tx, d_rx, d_to;
    op_e               eng_op;
    logic [DATA_W-1:0] tx_b, rx_b;
    logic              ctl_ie, ctl_go, ctl_init, ctl_dir;

    assign core_rst_n = rst_n & rst_done;

    sgw_rstseq #(.RST_CYC(RST_CYC)) rstseq_i (
        .clk(clk), .rst_n(rst_n), .soft_req(soft_req), .rst_done(rst_done)
    );

    sgw_sync #(.STAGES(SYNC_FF), .IDLE_VAL(1'b1)) sync_i (
        .clk(clk), .rst_n(core_rst_n), .d(line_in), .q(line_s)
    );

    sgw_regs #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) regs_i (
        .clk(clk), .rst_n(core_rst_n), .wr(reg_wr), .rd(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .rst_done(rst_done), .soft_req(soft_req), .start(eng_start),
        .op(eng_op), .tx_byte(tx_b), .done_tx(d_tx), .done_rx(d_rx),
        .done_to(d_to), .rx_byte(rx_b), .irq(irq), .ie(ctl_ie),
        .go(ctl_go), .init(ctl_init), .dir(ctl_dir)
    );

    sgw_engine #(
        .BIT_W(DATA_W), .CELL(CELL), .BIT1_LOW(BIT1_LOW), .BIT0_LOW(BIT0_LOW),
        .BREAK_LOW(BREAK_LOW), .BREAK_REC(BREAK_REC), .RX_WAIT(RX_WAIT),
        .RX_SAMPLE(RX_SAMPLE)
    ) eng_i (
        .clk(clk), .rst_n(core_rst_n), .start(eng_start), .op(eng_op),
        .tx_byte(tx_b), .line_s(line_s), .drive_low(line_drive_low),
        .busy(eng_busy), .done_tx(d_tx), .done_rx(d_rx), .done_to(d_to),
        .rx_byte(rx_b)
    );
endmodule

// File: rtl/sgw_master_chk.sv
// Property checker for sgw_master, attached by bind below.
// Assumes rst_n is synchronous and held for at least one edge.
module sgw_master_chk #(
    parameter int BREAK_LOW = 40
) (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic drive_low,
    input logic ie,
    input logic go,
    input logic init,
    input logic dir,
    input logic busy,
    input logic rst_done
);
    int lowrun;

    // length of the current drive-low run
    always_ff @(posedge clk) begin
        if (!rst_n)         lowrun <= 0;
        else if (drive_low) lowrun <= lowrun + 1;
        else                lowrun <= 0;
    end

    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);

    // R4
    go_tracks_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go == busy);

    // R5
    init_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) |-> !init);

    // R6
    recv_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && dir && !init) |-> !drive_low);

    // R11
    hold_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_done && $past(!rst_done)) |-> !drive_low);

    // R5
    low_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowrun <= BREAK_LOW);
endmodule

bind sgw_master sgw_master_chk #(.BREAK_LOW(BREAK_LOW)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .drive_low(line_drive_low),
    .ie(ctl_ie), .go(ctl_go), .init(ctl_init), .dir(ctl_dir),
    .busy(eng_busy), .rst_done(rst_done)
);

// File: tb/sgw_master_tb_top.sv
// Self-checking bench: sweeps every send and receive byte and checks the
// break, timeout, flag, interrupt, lock and soft-reset behaviour.
module sgw_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CELL = 24, B1 = 5, B0 = 15, BRK = 40, BREC = 12;
    localparam int RXW = 64, RXS = 10, RSTC = 8, MAJ = 3, MIN = 7;
    localparam logic [4:0] AREV = 5'h00, ATX = 5'h04, ARX = 5'h08, ACT = 5'h0C;
    localparam logic [4:0] AEV = 5'h10, ASC = 5'h14, AST = 5'h18;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, dl;
    logic       slave_low = 1'b0;
    logic       line;

    assign line = !(dl | slave_low);

    sgw_master #(
        .REV_MAJOR(MAJ), .REV_MINOR(MIN), .CELL(CELL), .BIT1_LOW(B1),
        .BIT0_LOW(B0), .BREAK_LOW(BRK), .BREAK_REC(BREC), .RX_WAIT(RXW),
        .RX_SAMPLE(RXS), .RST_CYC(RSTC), .SYNC_FF(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq),
        .line_drive_low(dl), .line_in(line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // pulse monitor on the drive-low output, sampled at falling edges
    int   st[16];
    int   wd[16];
    int   np = 0;
    logic pdl = 1'b0;
    always @(negedge clk) begin
        if (dl === 1'b1 && !pdl && np < 16) st[np] = cyc;
        if (dl === 1'b0 && pdl && np < 16) begin
            wd[np] = cyc - st[np];
            np = np + 1;
        end
        pdl = (dl === 1'b1);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_idle;
        logic [7:0] v;
        v = 8'h10;
        for (int k = 0; k < 4000 && v[4]; k++) rd_reg(ACT, v);
    endtask

    // decode the captured pulses into a byte; bad counts shape errors
    task automatic decode(output int val, output int bad);
        val = 0; bad = (np != 8) ? 1 : 0;
        for (int i = 0; i < 8 && i < np; i++) begin
            if (wd[i] == B1) val |= (1 << i);
            else if (wd[i] != B0) bad++;
            if (i > 0 && st[i] - st[i-1] != CELL) bad++;
        end
    endtask

    // slave model: send nbits of b, LSB first
    task automatic slave_send(input logic [7:0] b, input int nbits);
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            int lo;
            lo = b[i] ? B1 : B0;
            slave_low = 1'b1;
            repeat (lo) @(negedge clk);
            slave_low = 1'b0;
            repeat (CELL - lo) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        logic [7:0] v;
        int val, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(AST, v); chk("R1 status during hold", v, 8'h00);
        repeat (RSTC + 2) @(negedge clk);
        rd_reg(AST, v); chk("R1 status ready", v, 8'h01);
        rd_reg(ACT, v); chk("R1 ctrl", v, 0);
        rd_reg(AEV, v); chk("R1 events", v, 0);
        rd_reg(ATX, v); chk("R1 txd", v, 0);
        rd_reg(ARX, v); chk("R1 rxd", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 line released", dl, 0);
        // R2 revision
        rd_reg(AREV, v); chk("R2 revision", v, (MAJ << 4) | MIN);

        // R3 R4 R9 send sweep
        for (int b = 0; b < 256; b++) begin
            wr_reg(ATX, 8'(b));
            np = 0;
            wr_reg(ACT, 8'h70);
            wait_idle();
            decode(val, bad);
            chk("R3 sent byte", val, b);
            chk("R3 pulse shape", bad, 0);
            chk("R9 irq on send", irq, 1);
            rd_reg(AEV, v); chk("R4 send flag", v, 8'h04);
            rd_reg(ACT, v); chk("R4 go cleared", v, 8'h60);
        end

        // R6 receive sweep
        for (int b = 0; b < 256; b++) begin
            np = 0;
            wr_reg(ACT, 8'h72);
            slave_send(8'(b), 8);
            wait_idle();
            chk("R6 master silent", np, 0);
            rd_reg(ARX, v); chk("R6 received byte", v, b);
            rd_reg(AEV, v); chk("R6 recv flag", v, 8'h02);
        end

        // R7 silent slave and partial byte
        wr_reg(ACT, 8'h72);
        wait_idle();
        rd_reg(AEV, v); chk("R7 timeout flag silent", v, 8'h01);
        rd_reg(ARX, v); chk("R7 rxd kept silent", v, 8'hFF);
        wr_reg(ACT, 8'h72);
        slave_send(8'h00, 3);
        wait_idle();
        rd_reg(AEV, v); chk("R7 timeout flag partial", v, 8'h01);
        rd_reg(ARX, v); chk("R7 rxd kept partial", v, 8'hFF);

        // R5 break
        np = 0;
        wr_reg(ACT, 8'h74);
        wait_idle();
        chk("R5 break pulse count", np, 1);
        chk("R5 break width", wd[0], BRK);
        rd_reg(AEV, v); chk("R5 break flag", v, 8'h01);
        rd_reg(ACT, v); chk("R5 init and go cleared", v, 8'h60);

        // R8 R9 clear on read with interrupt disabled
        wr_reg(ATX, 8'h5A);
        wr_reg(ACT, 8'h30);
        wait_idle();
        chk("R9 irq masked", irq, 0);
        rd_reg(AEV, v); chk("R8 first read", v, 8'h04);
        rd_reg(AEV, v); chk("R8 second read", v, 8'h00);

        // R10 lock while busy
        wr_reg(ATX, 8'hA5);
        np = 0;
        wr_reg(ACT, 8'h70);
        wr_reg(ACT, 8'h00);
        wr_reg(ATX, 8'h3C);
        rd_reg(ACT, v); chk("R10 ctrl during op", v, 8'h10);
        wait_idle();
        decode(val, bad);
        chk("R10 byte unchanged", val, 8'hA5);
        rd_reg(ACT, v); chk("R10 ctrl after op", v, 8'h00);
        rd_reg(AEV, v); chk("R10 send flag", v, 8'h04);

        // R12 readback of settings
        wr_reg(ASC, 8'h01);
        rd_reg(ASC, v); chk("R12 auto-idle", v, 8'h01);
        wr_reg(ACT, 8'h61);
        rd_reg(ACT, v); chk("R12 ctrl settings", v, 8'h61);

        // R11 soft reset with a pending flag
        wr_reg(ACT, 8'h74);
        wait_idle();
        chk("R9 irq before soft reset", irq, 1);
        wr_reg(ASC, 8'h03);
        rd_reg(AST, v); chk("R11 status during hold", v, 8'h00);
        repeat (RSTC + 2) @(negedge clk);
        rd_reg(AST, v); chk("R11 status ready", v, 8'h01);
        rd_reg(ACT, v); chk("R11 ctrl reset", v, 8'h00);
        rd_reg(AEV, v); chk("R11 events reset", v, 8'h00);
        rd_reg(ASC, v); chk("R11 config reset", v, 8'h00);
        rd_reg(ARX, v); chk("R11 rxd reset", v, 8'h00);
        chk("R11 irq low", irq, 0);

        summary();
    end
endmodule